// File: doc/BRIEF.md
# Master Clock Source Selector and Prescaler

This block produces the master clock of a subsystem as a clock-enable pulse train. It chooses one of four source tick streams, the slow, main, PLL and USB PLL clocks, each given as a single-cycle enable on the common fabric clock. It then divides the chosen stream by a programmable ratio: any power of two from 1 to 64, or 3. Each output pulse marks one period of the master clock.

Software writes a control word that holds a 2-bit source field and a 3-bit prescaler field. The block does not apply the word at once. The word waits until the current divided period ends, so a switch never cuts a master clock period short. A ready flag drops on every write. It rises again once the new setting has run for a fixed number of ticks of its own source.

Top module: `mck_clock_gen`

## Requirements
- R1: After reset the slow clock (source code 0) is selected with divide-by-1, and `mck_ready` is 1.
- R2: Source code 0 selects `src_tick[0]` (slow), 1 selects `src_tick[1]` (main), 2 selects `src_tick[2]` (PLL) and 3 selects `src_tick[3]` (USB PLL).
- R3: Prescaler codes 0 to 6 divide the selected tick stream by 1, 2, 4, 8, 16, 32 and 64. With periodic source ticks, the spacing of `mck_tick` pulses is the ratio times the source period.
- R4: Prescaler code 7 divides by 3, giving one pulse for every three ticks of the selected source.
- R5: `mck_tick` is a single-cycle pulse. It is high in the cycle after the source tick that completes a divided period.
- R6: A cycle with `cfg_wr` high makes `mck_ready` 0 from the next cycle on, and it stays 0 until the new setting is established.
- R7: A written setting takes effect only at the end of the current divided period. The pulse that ends that period keeps the old spacing, and no period is shortened.
- R8: `mck_ready` becomes 1 in the cycle after the second tick of the new source that follows the switch boundary.
- R9: A write that repeats the active source and prescaler values still clears `mck_ready`. The flag rises again only after a boundary and the same settle delay.
- R10: A second write made before the first one is applied replaces it. Only the latest value is applied at the boundary.
- R11: Ticks of sources that are not selected produce no `mck_tick` and do not advance the ready settle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock; all source ticks are enables on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | NSRC (4) | Per-source single-cycle tick enables: slow, main, PLL, USB PLL |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_sel | input | SEL_W (2) | Source-select field of the control word |
| cfg_pres | input | PRES_W (3) | Prescaler field of the control word |
| mck_tick | output | 1 | Master clock enable pulse |
| mck_ready | output | 1 | High when the last written setting is established |

## Verification
The bench uses the default parameters: four sources, a 3-bit prescaler field that reaches divide-by-64, and a settle count of two ticks. Free-running tick streams with periods of 7, 3, 2 and 1 cycles give every source a distinct pulse spacing, so a wrong source or ratio shows as a wrong interval, up to 448 cycles apart. In hand-driven tick phases, each tick of the new source is placed one at a time. This exposes the boundary-only switch, the exact cycle in which ready rises, and the replacement of a pending write.

// File: rtl/mck_pkg.sv
package mck_pkg;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_UPLL = 2'd3
  } mck_src_e;

  // Division ratio for a prescaler code: the all-ones code means 3,
  // every other code n means 2**n.
  function automatic int unsigned div_ratio(input int unsigned code,
                                            input int unsigned pres_w);
    if (code == ((1 << pres_w) - 1)) begin
      return 3;
    end
    return 1 << code;
  endfunction

endpackage

// File: rtl/mck_src_mux.sv
module mck_src_mux #(
  parameter int NSRC  = 4,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] act_sel,
  output logic             sel_tick
);

  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign hit[i] = src_tick[i] & (act_sel == SEL_W'(i));
  end

  assign sel_tick = |hit;

endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler #(
  parameter int PRES_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_tick,
  input  logic [PRES_W-1:0] act_pres,
  output logic              boundary,
  output logic              mck_tick
);

  localparam int MAX_LOG = (1 << PRES_W) - 2;
  localparam int CNT_W   = (MAX_LOG < 2) ? 2 : MAX_LOG;
  localparam int LIM_W   = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [LIM_W-1:0] limit;
  logic             last;
  logic             tick_n;
  logic             tick_q;

  always_comb begin
    limit = LIM_W'(mck_pkg::div_ratio(int'(act_pres), PRES_W));
    last  = ({1'b0, cnt_q} == (limit - LIM_W'(1)));
    boundary = sel_tick & last;
    tick_n   = boundary;
    cnt_n    = cnt_q;
    if (sel_tick) begin
      if (last) begin
        cnt_n = '0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign mck_tick = tick_q;

endmodule

// File: rtl/mck_switch_ctrl.sv
module mck_switch_ctrl #(
  parameter int SEL_W        = 2,
  parameter int PRES_W       = 3,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [PRES_W-1:0] cfg_pres,
  input  logic              sel_tick,
  input  logic              boundary,
  output logic [SEL_W-1:0]  act_sel,
  output logic [PRES_W-1:0] act_pres,
  output logic              pend_valid,
  output logic              mck_ready
);

  localparam int ST_W = $clog2(SETTLE_TICKS + 1);

  logic [SEL_W-1:0]  act_sel_q,  act_sel_n;
  logic [PRES_W-1:0] act_pres_q, act_pres_n;
  logic [SEL_W-1:0]  pend_sel_q, pend_sel_n;
  logic [PRES_W-1:0] pend_pres_q, pend_pres_n;
  logic              pend_vld_q, pend_vld_n;
  logic [ST_W-1:0]   settle_q,   settle_n;
  logic              ready_q,    ready_n;
  logic              swap;

  always_comb begin
    swap        = boundary & pend_vld_q;
    act_sel_n   = swap ? pend_sel_q  : act_sel_q;
    act_pres_n  = swap ? pend_pres_q : act_pres_q;
    pend_sel_n  = cfg_wr ? cfg_sel  : pend_sel_q;
    pend_pres_n = cfg_wr ? cfg_pres : pend_pres_q;
    pend_vld_n  = cfg_wr | (pend_vld_q & ~swap);

    settle_n = settle_q;
    if (swap) begin
      settle_n = ST_W'(SETTLE_TICKS);
    end else if (sel_tick && (settle_q != '0)) begin
      settle_n = settle_q - ST_W'(1);
    end

    ready_n = ready_q;
    if (cfg_wr) begin
      ready_n = 1'b0;
    end else if (!swap && sel_tick && !pend_vld_q &&
                 (settle_q == ST_W'(1))) begin
      ready_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel_q   <= '0;
      act_pres_q  <= '0;
      pend_sel_q  <= '0;
      pend_pres_q <= '0;
      pend_vld_q  <= 1'b0;
      settle_q    <= '0;
      ready_q     <= 1'b1;
    end else begin
      act_sel_q   <= act_sel_n;
      act_pres_q  <= act_pres_n;
      pend_sel_q  <= pend_sel_n;
      pend_pres_q <= pend_pres_n;
      pend_vld_q  <= pend_vld_n;
      settle_q    <= settle_n;
      ready_q     <= ready_n;
    end
  end

  assign act_sel    = act_sel_q;
  assign act_pres   = act_pres_q;
  assign pend_valid = pend_vld_q;
  assign mck_ready  = ready_q;

endmodule

// File: rtl/mck_clock_gen.sv
module mck_clock_gen #(
  parameter int NSRC         = 4,
  parameter int SEL_W        = $clog2(NSRC),
  parameter int PRES_W       = 3,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [PRES_W-1:0] cfg_pres,
  output logic              mck_tick,
  output logic              mck_ready
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sel_tick;
  logic              boundary;
  logic [SEL_W-1:0]  act_sel;
  logic [PRES_W-1:0] act_pres;
  logic              pend_valid;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  mck_src_mux #(
    .NSRC  (NSRC),
    .SEL_W (SEL_W)
  ) u_mux (
    .src_tick (src_tick),
    .act_sel  (act_sel),
    .sel_tick (sel_tick)
  );

  mck_prescaler #(
    .PRES_W (PRES_W)
  ) u_pres (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sel_tick (sel_tick),
    .act_pres (act_pres),
    .boundary (boundary),
    .mck_tick (mck_tick)
  );

  mck_switch_ctrl #(
    .SEL_W        (SEL_W),
    .PRES_W       (PRES_W),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_pres   (cfg_pres),
    .sel_tick   (sel_tick),
    .boundary   (boundary),
    .act_sel    (act_sel),
    .act_pres   (act_pres),
    .pend_valid (pend_valid),
    .mck_ready  (mck_ready)
  );

endmodule

// File: rtl/mck_clock_gen_chk.sv
module mck_clock_gen_chk #(
  parameter int NSRC   = 4,
  parameter int SEL_W  = 2,
  parameter int PRES_W = 3
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [NSRC-1:0]   src_tick,
  input logic              cfg_wr,
  input logic              sel_tick,
  input logic              boundary,
  input logic [SEL_W-1:0]  act_sel,
  input logic [PRES_W-1:0] act_pres,
  input logic              pend_valid,
  input logic              mck_tick,
  input logic              mck_ready
);

  assert_wr_drops_ready_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg_wr |=> !mck_ready);

  assert_setting_holds_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !boundary |=> ($stable(act_sel) && $stable(act_pres)));

  assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mck_tick |-> $past(|src_tick));

  assert_ready_rise_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(mck_ready) |-> ($past(sel_tick) && !pend_valid));

  assert_div1_each_tick_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel_tick && (act_pres == '0)) |=> mck_tick);

endmodule

bind mck_clock_gen mck_clock_gen_chk #(
  .NSRC   (NSRC),
  .SEL_W  (SEL_W),
  .PRES_W (PRES_W)
) u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .src_tick   (src_tick),
  .cfg_wr     (cfg_wr),
  .sel_tick   (sel_tick),
  .boundary   (boundary),
  .act_sel    (act_sel),
  .act_pres   (act_pres),
  .pend_valid (pend_valid),
  .mck_tick   (mck_tick),
  .mck_ready  (mck_ready)
);

// File: tb/mck_clock_gen_tb.sv
module mck_clock_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4;

  logic       clk;
  logic       rst_n;
  logic [3:0] src_tick;
  logic [3:0] man_tick;
  logic [3:0] auto_tick;
  logic       auto_en;
  logic       cfg_wr;
  logic [1:0] cfg_sel;
  logic [2:0] cfg_pres;
  logic       mck_tick;
  logic       mck_ready;

  int n_chk;
  int n_fail;
  int cyc;
  int auto_cnt;

  mck_clock_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_pres  (cfg_pres),
    .mck_tick  (mck_tick),
    .mck_ready (mck_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) auto_cnt <= auto_cnt + 1;

  // source periods in cycles: slow 7, main 3, PLL 2, USB PLL 1
  function automatic int src_period(input int s);
    case (s)
      0: return 7;
      1: return 3;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int ratio(input int p);
    return (p == 7) ? 3 : (1 << p);
  endfunction

  assign auto_tick[0] = (auto_cnt % 7) == 0;
  assign auto_tick[1] = (auto_cnt % 3) == 0;
  assign auto_tick[2] = (auto_cnt % 2) == 0;
  assign auto_tick[3] = 1'b1;
  assign src_tick = auto_en ? auto_tick : man_tick;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // all tasks start and end at a falling edge
  task automatic write_cfg(input int s, input int p, input string req);
    cfg_wr = 1'b1;
    cfg_sel = 2'(s);
    cfg_pres = 3'(p);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk(req, int'(mck_ready), 0);
  endtask

  task automatic man_step(input logic [3:0] mask);
    man_tick = mask;
    @(negedge clk);
    man_tick = 4'b0000;
  endtask

  task automatic wait_ready(input string req);
    int guard = 0;
    while (!mck_ready && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(req, int'(mck_ready), 1);
  endtask

  task automatic wait_pulse(output int t);
    int guard = 0;
    while (!mck_tick && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    t = cyc;
  endtask

  task automatic test_reset();
    chk("R1 ready after reset", int'(mck_ready), 1);
    chk("R1 no pulse after reset", int'(mck_tick), 0);
    man_step(4'b0001);
    chk("R1 slow div1 pulse", int'(mck_tick), 1);
    @(negedge clk);
    chk("R5 pulse single cycle", int'(mck_tick), 0);
  endtask

  task automatic test_ignore();
    man_step(4'b1110);
    chk("R11 unselected ticks ignored", int'(mck_tick), 0);
    man_step(4'b0110);
    chk("R11 unselected ticks ignored", int'(mck_tick), 0);
  endtask

  task automatic test_switch();
    write_cfg(1, 0, "R6 write clears ready");
    man_step(4'b0010);
    chk("R7 main tick before boundary", int'(mck_tick), 0);
    man_step(4'b0010);
    chk("R11 no settle before boundary", int'(mck_ready), 0);
    man_step(4'b0001);
    chk("R7 old source ends period", int'(mck_tick), 1);
    chk("R6 ready low at boundary", int'(mck_ready), 0);
    man_step(4'b0010);
    chk("R2 main selected", int'(mck_tick), 1);
    chk("R8 ready low after one tick", int'(mck_ready), 0);
    man_step(4'b0010);
    chk("R8 ready after two ticks", int'(mck_ready), 1);
  endtask

  task automatic measure(input int s, input int p, input string req);
    int t0;
    int t1;
    write_cfg(s, p, "R6 write clears ready");
    wait_ready("R8 ready returns");
    wait_pulse(t0);
    @(negedge clk);
    wait_pulse(t1);
    chk(req, t1 - t0, src_period(s) * ratio(p));
  endtask

  task automatic test_no_short();
    int t0;
    int t1;
    measure(3, 6, "R3 divide by 64");
    wait_pulse(t0);
    @(negedge clk);
    write_cfg(3, 0, "R6 write clears ready");
    wait_pulse(t1);
    chk("R7 period not shortened", t1 - t0, 64);
    @(negedge clk);
    chk("R7 new ratio after boundary", int'(mck_tick), 1);
    wait_ready("R8 ready after switch");
  endtask

  task automatic test_same_value();
    write_cfg(3, 0, "R9 same value clears ready");
    @(negedge clk);
    chk("R9 ready held low", int'(mck_ready), 0);
    man_step(4'b1000);
    chk("R9 ready low at boundary", int'(mck_ready), 0);
    man_step(4'b1000);
    chk("R9 ready low after one tick", int'(mck_ready), 0);
    man_step(4'b1000);
    chk("R9 ready after settle", int'(mck_ready), 1);
  endtask

  task automatic test_overwrite();
    write_cfg(1, 0, "R6 write clears ready");
    write_cfg(2, 0, "R10 second write");
    man_step(4'b1000);
    chk("R10 boundary pulse", int'(mck_tick), 1);
    man_step(4'b0010);
    chk("R10 first value not applied", int'(mck_tick), 0);
    man_step(4'b0010);
    chk("R10 no settle on stale source", int'(mck_ready), 0);
    man_step(4'b0100);
    chk("R10 latest value applied", int'(mck_tick), 1);
    chk("R8 ready low after one tick", int'(mck_ready), 0);
    man_step(4'b0100);
    chk("R10 ready after settle", int'(mck_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    cyc = 0;
    auto_cnt = 0;
    auto_en = 1'b0;
    man_tick = 4'b0000;
    cfg_wr = 1'b0;
    cfg_sel = 2'd0;
    cfg_pres = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    test_reset();
    test_ignore();
    test_switch();

    auto_en = 1'b1;
    measure(1, 0, "R2 main div1");
    measure(0, 1, "R2 slow div2");
    measure(2, 2, "R2 PLL div4");
    measure(1, 7, "R4 main div3");
    measure(0, 7, "R4 slow div3");
    for (int p = 0; p < 8; p++) begin
      measure(3, p, (p == 7) ? "R4 USB PLL div3" : "R3 USB PLL ratio");
    end
    measure(2, 6, "R3 PLL div64");
    test_no_short();

    auto_en = 1'b0;
    @(negedge clk);
    test_same_value();
    test_overwrite();

    finish_run();
  end

endmodule